// File: doc/BRIEF.md
# Lane-Splittable 16-bit Adder

This block adds two 16-bit operands in a single combinational path whose carry chain can be broken at run time. With both mode controls low it is an ordinary wrapping 16-bit adder. With the byte-split control high, the carry is stopped at the midpoint, so the upper and lower halves form two independent 8-bit sums. With the nibble-split control high, the carry is stopped at every fourth bit, so the result is four independent 4-bit sums.

Within each lane the result is the wrapped sum of that lane's operand bits. A carry that leaves a lane is dropped. The possible break positions are fixed by a parameter bitmap. Only the choice of which breaks are enabled changes while the block is running.

Internally the adder is widened by one spacer bit per break position. An enabled break sets both spacer bits to zero, which absorbs the carry. A disabled break sets the spacer bits to one and zero, which passes the carry through to the next bit.

Top module: `simd_part_adder`

## Requirements
- R1: With both split controls low, the result equals (a + b) mod 2^16.
- R2: With only the byte-split control high, result bits [7:0] equal (a[7:0] + b[7:0]) mod 2^8, and result bits [15:8] equal (a[15:8] + b[15:8]) mod 2^8.
- R3: With the nibble-split control high, every 4-bit field [4k+3:4k] for k = 0..3 of the result equals the sum of the matching operand fields, mod 2^4.
- R4: When both controls are high, the nibble split wins, and the result is the same as in R3.
- R5: A carry generated in one lane never changes any higher lane. For example, in byte-split mode 0x00FF + 0x0001 gives 0x0000, and in nibble-split mode 0x0FFF + 0x0111 gives 0x0000.
- R6: The result is a pure function of the present inputs, with no clock and no stored state. It is valid in the same cycle in which the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| nib_split_i | input | 1 | Split into four 4-bit lanes |
| byte_split_i | input | 1 | Split into two 8-bit lanes |
| sum_o | output | 16 | Lane-wise wrapped sum |

## Verification
Every result is due with zero cycles of latency, because the path from the operands to `sum_o` has no register. The driver applies each operand pair and mode one time unit after a rising edge, and pushes the lane-masked expected sum into the scoreboard queue. The monitor pops and compares on the next falling edge, after the combinational path has settled and before the next stimulus arrives. Carry-boundary patterns, such as all-ones plus one in each mode, show whether a carry crosses a disabled or an enabled break.

// File: rtl/spa_pkg.sv
package spa_pkg;
  // Default geometry: 16-bit datapath, break positions at bits 4, 8 and 12.
  localparam int unsigned SPA_W      = 16;
  localparam logic [15:0] SPA_PT_MAP = 16'h1110;
  localparam int unsigned SPA_BYTE_W = 8;
  localparam int unsigned SPA_NIB_W  = 4;
endpackage

// File: rtl/spa_cut_decode.sv
// Turns the two mode controls into a per-bit break vector.
// Bit p of cut_o is high when the carry into bit p is blocked.
module spa_cut_decode #(
  parameter int unsigned W      = spa_pkg::SPA_W,
  parameter logic [W-1:0] PT_MAP = spa_pkg::SPA_PT_MAP,
  parameter int unsigned BYTE_W = spa_pkg::SPA_BYTE_W
) (
  input  logic         nib_split_i,
  input  logic         byte_split_i,
  output logic [W-1:0] cut_o
);
  for (genvar p = 0; p < W; p++) begin : g_bit
    if (PT_MAP[p] && (p > 0)) begin : g_pt
      localparam bit ON_BYTE = ((p % BYTE_W) == 0);
      // Nibble split enables every break; byte split enables only those on byte edges.
      assign cut_o[p] = nib_split_i | (byte_split_i & ON_BYTE);
    end else begin : g_none
      assign cut_o[p] = 1'b0;
    end
  end
endmodule

// File: rtl/spa_gap_expand.sv
// Spreads the operands into a wider word with one spacer bit before each break position.
module spa_gap_expand #(
  parameter int unsigned W      = spa_pkg::SPA_W,
  parameter logic [W-1:0] PT_MAP = spa_pkg::SPA_PT_MAP,
  parameter int unsigned XW     = W + 3
) (
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic [W-1:0]  cut_i,
  output logic [XW-1:0] xa_o,
  output logic [XW-1:0] xb_o
);
  // Index of data bit p in the widened word.
  function automatic int xidx(input int p);
    int n;
    n = 0;
    for (int k = 1; k <= p; k++) if (PT_MAP[k]) n++;
    return p + n;
  endfunction

  for (genvar p = 0; p < W; p++) begin : g_bit
    assign xa_o[xidx(p)] = a_i[p];
    assign xb_o[xidx(p)] = b_i[p];
    if (PT_MAP[p] && (p > 0)) begin : g_gap
      // Passing break: 1+0 forwards the carry. Blocking break: 0+0 absorbs it.
      assign xa_o[xidx(p)-1] = ~cut_i[p];
      assign xb_o[xidx(p)-1] = 1'b0;
    end
  end
endmodule

// File: rtl/spa_gap_compact.sv
// Drops the spacer bits from the widened sum.
module spa_gap_compact #(
  parameter int unsigned W      = spa_pkg::SPA_W,
  parameter logic [W-1:0] PT_MAP = spa_pkg::SPA_PT_MAP,
  parameter int unsigned XW     = W + 3
) (
  input  logic [XW-1:0] xs_i,
  output logic [W-1:0]  sum_o
);
  function automatic int xidx(input int p);
    int n;
    n = 0;
    for (int k = 1; k <= p; k++) if (PT_MAP[k]) n++;
    return p + n;
  endfunction

  for (genvar p = 0; p < W; p++) begin : g_bit
    assign sum_o[p] = xs_i[xidx(p)];
  end
endmodule

// File: rtl/simd_part_adder.sv
module simd_part_adder #(
  parameter int unsigned W      = spa_pkg::SPA_W,
  parameter logic [W-1:0] PT_MAP = spa_pkg::SPA_PT_MAP,
  parameter int unsigned BYTE_W = spa_pkg::SPA_BYTE_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         nib_split_i,
  input  logic         byte_split_i,
  output logic [W-1:0] sum_o
);
  // Number of usable break positions (bit 0 cannot hold one).
  localparam int unsigned NPTS = $countones(PT_MAP[W-1:1]);
  localparam int unsigned XW   = W + NPTS;

  logic [W-1:0]  cut;
  logic [XW-1:0] xa;
  logic [XW-1:0] xb;
  logic [XW-1:0] xs;

  spa_cut_decode #(.W(W), .PT_MAP(PT_MAP), .BYTE_W(BYTE_W)) u_dec (
    .nib_split_i (nib_split_i),
    .byte_split_i(byte_split_i),
    .cut_o       (cut)
  );

  spa_gap_expand #(.W(W), .PT_MAP(PT_MAP), .XW(XW)) u_exp (
    .a_i  (a_i),
    .b_i  (b_i),
    .cut_i(cut),
    .xa_o (xa),
    .xb_o (xb)
  );

  // A single wide carry chain; the spacer bits decide where it breaks.
  assign xs = xa + xb;

  spa_gap_compact #(.W(W), .PT_MAP(PT_MAP), .XW(XW)) u_cmp (
    .xs_i (xs),
    .sum_o(sum_o)
  );
endmodule

// File: rtl/spa_check.sv
// Lane-level property checks, written against plain narrow adds.
module spa_check #(
  parameter int unsigned W = 16
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         nib_split_i,
  input logic         byte_split_i,
  input logic [W-1:0] sum_o
);
  logic [W-1:0] full_ref;
  assign full_ref = a_i + b_i;

  always_comb begin
    if (!nib_split_i && !byte_split_i) begin
      a_r1_full_wrap: assert (sum_o == full_ref)
        else $error("R1 full add mismatch");
    end
    if (byte_split_i && !nib_split_i) begin
      a_r2_byte_low: assert (sum_o[7:0] == 8'(a_i[7:0] + b_i[7:0]))
        else $error("R2 low byte mismatch");
      // R5: the low byte's carry must not reach the high byte.
      a_r2_byte_high: assert (sum_o[15:8] == 8'(a_i[15:8] + b_i[15:8]))
        else $error("R2 high byte mismatch");
    end
  end

  for (genvar k = 0; k < W/4; k++) begin : g_nib
    always_comb begin
      // R4: this check applies whenever nibble split is high, whatever byte split is.
      if (nib_split_i) begin
        a_r3_nib_lane: assert (sum_o[4*k +: 4] == 4'(a_i[4*k +: 4] + b_i[4*k +: 4]))
          else $error("R3 nibble lane mismatch");
      end
    end
  end
endmodule

bind simd_part_adder spa_check #(.W(W)) u_chk (
  .a_i         (a_i),
  .b_i         (b_i),
  .nib_split_i (nib_split_i),
  .byte_split_i(byte_split_i),
  .sum_o       (sum_o)
);

// File: tb/simd_part_adder_tb_top.sv
module simd_part_adder_tb_top;
  logic        clk;
  logic        rst_n;
  logic [15:0] a;
  logic [15:0] b;
  logic        nib;
  logic        byt;
  logic [15:0] sum;

  int n_checks;
  int n_fail;
  bit done;

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  simd_part_adder dut_i (
    .a_i         (a),
    .b_i         (b),
    .nib_split_i (nib),
    .byte_split_i(byt),
    .sum_o       (sum)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Expected value: sum each lane separately, using lane masks.
  function automatic logic [15:0] model(input logic [15:0] x, input logic [15:0] y,
                                        input logic n, input logic bm);
    logic [16:0] r;
    logic [16:0] m;
    logic [16:0] t;
    r = '0;
    for (int k = 0; k < 4; k++) begin
      if (n) m = 17'hF << (4*k);
      else if (bm) m = (k < 2) ? 17'h00FF << (8*k) : 17'h0;
      else m = (k == 0) ? 17'hFFFF : 17'h0;
      t = ({1'b0, x} & m) + ({1'b0, y} & m);
      r = r | (m & t);
    end
    return r[15:0];
  endfunction

  task automatic drive(input logic [15:0] x, input logic [15:0] y,
                       input logic n, input logic bm, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    a = x; b = y; nib = n; byt = bm;
    e.exp = model(x, y, n, bm);
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  // Monitor: result has zero latency, so compare at the falling edge after the drive.
  always @(negedge clk) begin
    if (rst_n && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_checks++;
      if (sum !== e.exp) begin
        n_fail++;
        $display("FAIL %s: got 0x%04h expected 0x%04h (a=%04h b=%04h nib=%0b byte=%0b)",
                 e.tag, sum, e.exp, a, b, nib, byt);
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] pats [12];
    n_checks = 0;
    n_fail = 0;
    done = 1'b0;
    rst_n = 1'b0;
    a = '0; b = '0; nib = 1'b0; byt = 1'b0;
    pats = '{16'h0000, 16'hFFFF, 16'h0001, 16'h00FF, 16'h0FFF, 16'h8888,
             16'h1234, 16'hABCD, 16'h7FFF, 16'h8000, 16'hF0F0, 16'h5A5A};
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Idle inputs give a zero result.
    drive(16'h0000, 16'h0000, 1'b0, 1'b0, "R1 idle");
    // R6: a new input each cycle, compared in the same cycle.
    drive(16'hFFFF, 16'h0001, 1'b0, 1'b0, "R1 wrap");
    drive(16'h00FF, 16'h0001, 1'b0, 1'b0, "R1 carry crosses byte");
    drive(16'h00FF, 16'h0001, 1'b0, 1'b1, "R5 byte blocks carry");
    drive(16'h0FFF, 16'h0111, 1'b1, 1'b0, "R5 nibble blocks carry");
    drive(16'h000F, 16'h0001, 1'b0, 1'b1, "R2 nibble carry inside byte");
    drive(16'hFFFF, 16'hFFFF, 1'b1, 1'b1, "R4 both controls");
    for (int i = 0; i < 12; i++) begin
      for (int j = 0; j < 12; j++) begin
        drive(pats[i], pats[j], 1'b0, 1'b0, "R1 pattern");
        drive(pats[i], pats[j], 1'b0, 1'b1, "R2 pattern");
        drive(pats[i], pats[j], 1'b1, 1'b0, "R3 pattern");
        drive(pats[i], pats[j], 1'b1, 1'b1, "R4 pattern");
      end
    end
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule